// File: doc/BRIEF.md
# Host Service Request Arbiter

This block keeps, for each of sixteen channels, a two-bit service request field owned jointly by a host and a service engine, and a two-bit priority code owned by the host. The host asks for work on a channel by writing a nonzero request code into an idle field. It then reads the field back until it returns to zero. The engine takes one granted channel at a time and reports completion with a single-cycle done pulse. That pulse clears the field, which closes the handshake.

The selector runs a repeating round of seven slots that favours high-priority channels four times, middle-priority channels twice and low-priority channels once. When no pending channel sits at a slot's level, the slot goes to a neighbouring level instead of being wasted. Inside a level, channels take turns in ring order. A channel whose priority code is zero is never chosen, even while its request is pending.

Top module: `hsr_arbiter`

## Requirements
- R1: After a synchronous active-high reset every request field reads 00, every priority code reads 00, `svc_valid` is low and `host_wr_err` is low.
- R2: A host request write of a nonzero code to a channel whose field is 00 stores that code, and it is visible on the read port from the next cycle. A write of code 00 to an idle field leaves it at 00.
- R3: A host request write to a channel whose field is nonzero leaves the field unchanged. `host_wr_err` is high in the cycle after that write, and only for writes that were rejected.
- R4: A priority write always takes effect from the next cycle. The codes are 00 disabled, 01 low, 10 middle and 11 high. `host_rd_req` and `host_rd_prio` show the fields of channel `host_rd_ch` combinationally.
- R5: A channel with priority code 00 is never granted, whatever its request field holds.
- R6: While no grant is held and some enabled channel is pending, the next clock edge raises `svc_valid` with that channel on `svc_ch` and its field value on `svc_code`. All three outputs stay unchanged until `svc_done`.
- R7: `svc_done` while `svc_valid` is high clears the granted channel's field and drops `svc_valid` at the same edge. The next grant comes one cycle later at the earliest. `svc_done` without a grant has no effect.
- R8: Each grant uses one slot of a seven-slot round whose levels are, in order, high, middle, high, low, high, middle, high. The round starts at its first slot after reset.
- R9: If the slot's level has no pending enabled channel, the grant goes to the highest lower level that has one. If no lower level has one either, it goes to the lowest higher level that has one.
- R10: Within a level, the search starts at the channel after the one last granted at that level and wraps around. After reset it starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_we | input | 1 | Host request-field write strobe |
| host_req_ch | input | 4 | Channel addressed by the request write |
| host_req_code | input | 2 | Request code to write |
| host_prio_we | input | 1 | Host priority write strobe |
| host_prio_ch | input | 4 | Channel addressed by the priority write |
| host_prio_code | input | 2 | Priority code to write |
| host_rd_ch | input | 4 | Channel shown on the read outputs |
| host_rd_req | output | 2 | Request field of `host_rd_ch` |
| host_rd_prio | output | 2 | Priority code of `host_rd_ch` |
| host_wr_err | output | 1 | Pulse marking a rejected request write |
| svc_valid | output | 1 | A granted channel is held for the engine |
| svc_ch | output | 4 | Granted channel number |
| svc_code | output | 2 | Request code of the granted channel |
| svc_done | input | 1 | Engine completion pulse for the held grant |

## Verification
The hardest situations to reach from the ports depend on hidden state: the current slot of the round and the per-level ring pointers. A grant that falls back upward needs a low slot to come up while only higher levels have work. Reloading a ring pointer needs several requests to arrive together, before any of them is granted. The directed part of the bench keeps one grant open by withholding done while it loads the other requests, and then releases the grants one by one, so each expected channel follows from slot counting alone. A random phase then mixes writes aimed at the granted channel, including ones that coincide with done, with priority changes and variable engine latency, and checks every cycle against a behavioural model.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef enum logic [1:0] {
        PR_OFF  = 2'b00,
        PR_LOW  = 2'b01,
        PR_MID  = 2'b10,
        PR_HIGH = 2'b11
    } prio_e;

    localparam int ROUND_LEN = 7;

    // Level wanted by a given slot of the seven-slot round.
    function automatic logic [1:0] slot_level(input logic [2:0] slot);
        case (slot)
            3'd1, 3'd5: return 2'd2;
            3'd3:       return 2'd1;
            default:    return 2'd3;
        endcase
    endfunction

    // Wanted level first, then lower levels downward, then higher levels upward.
    // have[1] = low, have[2] = middle, have[3] = high. Returns 0 when nothing pends.
    function automatic logic [1:0] choose_level(input logic [1:0] want,
                                                input logic [3:1] have);
        logic [1:0] r;
        case (want)
            2'd3:    r = have[3] ? 2'd3 : have[2] ? 2'd2 : have[1] ? 2'd1 : 2'd0;
            2'd2:    r = have[2] ? 2'd2 : have[1] ? 2'd1 : have[3] ? 2'd3 : 2'd0;
            default: r = have[1] ? 2'd1 : have[2] ? 2'd2 : have[3] ? 2'd3 : 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hsr_regs.sv
module hsr_regs #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_we,
    input  logic [CW-1:0]     req_ch,
    input  logic [1:0]        req_code,
    input  logic              prio_we,
    input  logic [CW-1:0]     prio_ch,
    input  logic [1:0]        prio_code,
    input  logic              clr_en,
    input  logic [CW-1:0]     clr_ch,
    output logic [2*NUM_CH-1:0] req_flat,
    output logic [2*NUM_CH-1:0] prio_flat,
    output logic              wr_err
);
    import hsr_pkg::*;

    logic busy_target;
    assign busy_target = (req_flat[2*req_ch +: 2] != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= req_we && busy_target;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [1:0] rq;
        prio_e      pq;

        always_ff @(posedge clk) begin
            if (rst) begin
                rq <= 2'b00;
                pq <= PR_OFF;
            end else begin
                if (clr_en && (clr_ch == CW'(g)))
                    rq <= 2'b00;
                else if (req_we && (req_ch == CW'(g)) && (rq == 2'b00) && (req_code != 2'b00))
                    rq <= req_code;
                if (prio_we && (prio_ch == CW'(g)))
                    pq <= prio_e'(prio_code);
            end
        end

        assign req_flat[2*g +: 2]  = rq;
        assign prio_flat[2*g +: 2] = pq;
    end

endmodule

// File: rtl/hsr_rr_pick.sv
module hsr_rr_pick #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CW-1:0]     last,
    output logic              found,
    output logic [CW-1:0]     idx
);
    logic [CW-1:0] cand;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = '0;
        for (int off = 1; off <= NUM_CH; off++) begin
            cand = CW'((int'(last) + off) % NUM_CH);
            if (!found && mask[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

endmodule

// File: rtl/hsr_sched.sv
module hsr_sched #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*NUM_CH-1:0] req_flat,
    input  logic [2*NUM_CH-1:0] prio_flat,
    input  logic                take,
    output logic                pick_found,
    output logic [CW-1:0]       pick_ch
);
    import hsr_pkg::*;

    logic [2:0]    slot_q;
    logic [CW-1:0] last_q   [1:3];
    logic [3:1]    lvl_found;
    logic [CW-1:0] lvl_idx  [1:3];
    logic [1:0]    want, lvl;

    for (genvar L = 1; L <= 3; L++) begin : g_lvl
        logic [NUM_CH-1:0] m;
        for (genvar c = 0; c < NUM_CH; c++) begin : g_m
            assign m[c] = (req_flat[2*c +: 2] != 2'b00) && (prio_flat[2*c +: 2] == 2'(L));
        end
        hsr_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
            .mask (m),
            .last (last_q[L]),
            .found(lvl_found[L]),
            .idx  (lvl_idx[L])
        );
    end

    assign want       = slot_level(slot_q);
    assign lvl        = choose_level(want, lvl_found);
    assign pick_found = (lvl != 2'd0);

    always_comb begin
        case (lvl)
            2'd1:    pick_ch = lvl_idx[1];
            2'd2:    pick_ch = lvl_idx[2];
            2'd3:    pick_ch = lvl_idx[3];
            default: pick_ch = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= 3'd0;
            for (int l = 1; l <= 3; l++) last_q[l] <= CW'(NUM_CH - 1);
        end else if (take && pick_found) begin
            slot_q <= (slot_q == 3'(ROUND_LEN - 1)) ? 3'd0 : slot_q + 3'd1;
            case (lvl)
                2'd1:    last_q[1] <= pick_ch;
                2'd2:    last_q[2] <= pick_ch;
                default: last_q[3] <= pick_ch;
            endcase
        end
    end

endmodule

// File: rtl/hsr_arbiter.sv
module hsr_arbiter #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_req_we,
    input  logic [CH_W-1:0] host_req_ch,
    input  logic [1:0]      host_req_code,
    input  logic            host_prio_we,
    input  logic [CH_W-1:0] host_prio_ch,
    input  logic [1:0]      host_prio_code,
    input  logic [CH_W-1:0] host_rd_ch,
    output logic [1:0]      host_rd_req,
    output logic [1:0]      host_rd_prio,
    output logic            host_wr_err,
    output logic            svc_valid,
    output logic [CH_W-1:0] svc_ch,
    output logic [1:0]      svc_code,
    input  logic            svc_done
);
    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
        logic [1:0]      code;
    } grant_t;

    grant_t              grant_q;
    logic [2*NUM_CH-1:0] req_flat, prio_flat;
    logic                pick_found, take, clr_en;
    logic [CH_W-1:0]     pick_ch;

    assign take   = !grant_q.valid && pick_found;
    assign clr_en = grant_q.valid && svc_done;

    hsr_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req_we   (host_req_we),
        .req_ch   (host_req_ch),
        .req_code (host_req_code),
        .prio_we  (host_prio_we),
        .prio_ch  (host_prio_ch),
        .prio_code(host_prio_code),
        .clr_en   (clr_en),
        .clr_ch   (grant_q.ch),
        .req_flat (req_flat),
        .prio_flat(prio_flat),
        .wr_err   (host_wr_err)
    );

    hsr_sched #(.NUM_CH(NUM_CH)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .req_flat  (req_flat),
        .prio_flat (prio_flat),
        .take      (take),
        .pick_found(pick_found),
        .pick_ch   (pick_ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (clr_en) begin
            grant_q.valid <= 1'b0;
        end else if (take) begin
            grant_q.valid <= 1'b1;
            grant_q.ch    <= pick_ch;
            grant_q.code  <= req_flat[2*pick_ch +: 2];
        end
    end

    assign svc_valid    = grant_q.valid;
    assign svc_ch       = grant_q.ch;
    assign svc_code     = grant_q.code;
    assign host_rd_req  = req_flat[2*host_rd_ch +: 2];
    assign host_rd_prio = prio_flat[2*host_rd_ch +: 2];

endmodule

// File: rtl/hsr_arbiter_chk.sv
module hsr_arbiter_chk #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input logic                clk,
    input logic                rst,
    input logic                host_req_we,
    input logic                host_wr_err,
    input logic                svc_valid,
    input logic [CW-1:0]       svc_ch,
    input logic [1:0]          svc_code,
    input logic                svc_done,
    input logic [2*NUM_CH-1:0] req_flat,
    input logic [2*NUM_CH-1:0] prio_flat
);
    logic [2*NUM_CH-1:0] prio_prev;
    logic                valid_prev;
    logic [CW-1:0]       ch_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_prev  <= '0;
            valid_prev <= 1'b0;
            ch_prev    <= '0;
        end else begin
            prio_prev  <= prio_flat;
            valid_prev <= svc_valid;
            ch_prev    <= svc_ch;
        end
    end

    // R5
    enabled_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && !valid_prev) |-> (prio_prev[2*svc_ch +: 2] != 2'b00));

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && !svc_done) |=> (svc_valid && $stable(svc_ch) && $stable(svc_code)));

    // R6
    grant_code_chk: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> ((svc_code != 2'b00) && (svc_code == req_flat[2*svc_ch +: 2])));

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && svc_done) |=> (!svc_valid && (req_flat[2*ch_prev +: 2] == 2'b00)));

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        host_wr_err |-> $past(host_req_we));

endmodule

bind hsr_arbiter hsr_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req_we(host_req_we),
    .host_wr_err(host_wr_err),
    .svc_valid  (svc_valid),
    .svc_ch     (svc_ch),
    .svc_code   (svc_code),
    .svc_done   (svc_done),
    .req_flat   (req_flat),
    .prio_flat  (prio_flat)
);

// File: tb/tb_hsr_arbiter.sv
module tb_hsr_arbiter;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_req_we = 1'b0;
    logic [3:0] host_req_ch = '0;
    logic [1:0] host_req_code = '0;
    logic       host_prio_we = 1'b0;
    logic [3:0] host_prio_ch = '0;
    logic [1:0] host_prio_code = '0;
    logic [3:0] host_rd_ch = '0;
    logic [1:0] host_rd_req, host_rd_prio;
    logic       host_wr_err, svc_valid;
    logic [3:0] svc_ch;
    logic [1:0] svc_code;
    logic       svc_done = 1'b0;

    int  total = 0;
    int  fails = 0;
    bit  auto_en = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    hsr_arbiter dut (
        .clk(clk), .rst(rst),
        .host_req_we(host_req_we), .host_req_ch(host_req_ch), .host_req_code(host_req_code),
        .host_prio_we(host_prio_we), .host_prio_ch(host_prio_ch), .host_prio_code(host_prio_code),
        .host_rd_ch(host_rd_ch), .host_rd_req(host_rd_req), .host_rd_prio(host_rd_prio),
        .host_wr_err(host_wr_err), .svc_valid(svc_valid), .svc_ch(svc_ch),
        .svc_code(svc_code), .svc_done(svc_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_req [N];
    int m_prio[N];
    int m_last[1:3];
    int m_slot, m_valid, m_ch, m_code, m_err;

    task automatic model_pick(output bit ok, output int ch, output int lvl);
        int want;
        int order[3];
        int k;
        ok = 0; ch = 0; lvl = 0; k = 0;
        if (m_slot % 2 == 0) want = 3;
        else if (m_slot == 3) want = 1;
        else want = 2;
        for (int l = want; l >= 1; l--) begin order[k] = l; k++; end
        for (int l = want + 1; l <= 3; l++) begin order[k] = l; k++; end
        for (int s = 0; s < 3; s++) begin
            for (int off = 1; off <= N; off++) begin
                int c;
                c = (m_last[order[s]] + off) % N;
                if (!ok && m_req[c] != 0 && m_prio[c] == order[s]) begin
                    ok = 1; ch = c; lvl = order[s];
                end
            end
        end
    endtask

    always @(posedge clk) begin
        bit pk_ok;
        int pk_ch, pk_lvl, n_err, clr_ch;
        bit clr;
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_req[i] = 0; m_prio[i] = 0; end
            for (int l = 1; l <= 3; l++) m_last[l] = N - 1;
            m_slot = 0; m_valid = 0; m_ch = 0; m_code = 0; m_err = 0;
        end else begin
            clr = 0; clr_ch = 0;
            n_err = (host_req_we && m_req[host_req_ch] != 0) ? 1 : 0;
            if (m_valid != 0 && svc_done) begin
                clr = 1; clr_ch = m_ch; m_valid = 0;
            end else if (m_valid == 0) begin
                model_pick(pk_ok, pk_ch, pk_lvl);
                if (pk_ok) begin
                    m_valid = 1; m_ch = pk_ch; m_code = m_req[pk_ch];
                    m_last[pk_lvl] = pk_ch;
                    m_slot = (m_slot + 1) % 7;
                end
            end
            if (host_req_we && m_req[host_req_ch] == 0 && host_req_code != 0)
                m_req[host_req_ch] = int'(host_req_code);
            if (clr) m_req[clr_ch] = 0;
            if (host_prio_we) m_prio[host_prio_ch] = int'(host_prio_code);
            m_err = n_err;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(svc_valid == m_valid[0] &&
                (!svc_valid || (svc_ch == m_ch[3:0] && svc_code == m_code[1:0])),
                "R6/R8/R9/R10 model grant", {svc_valid, svc_ch, svc_code},
                (m_valid << 6) | (m_ch << 2) | m_code);
            chk(host_wr_err == m_err[0], "R3 model error pulse", host_wr_err, m_err);
            chk(host_rd_req == m_req[host_rd_ch][1:0] && host_rd_prio == m_prio[host_rd_ch][1:0],
                "R2/R4 model read port", {host_rd_req, host_rd_prio},
                (m_req[host_rd_ch] << 2) | m_prio[host_rd_ch]);
        end
    end

    // ---------------- engine emulation for the random phase ----------------
    always @(posedge clk) begin
        #1;
        if (auto_en) svc_done = svc_valid && ($urandom_range(2) == 0);
    end

    // ---------------- helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic probe(input int ch, output int rq, output int pr);
        host_rd_ch = 4'(ch);
        @(negedge clk);
        #1;
        rq = host_rd_req;
        pr = host_rd_prio;
    endtask

    task automatic wr_req(input int ch, input int code);
        host_req_we = 1'b1; host_req_ch = 4'(ch); host_req_code = 2'(code);
        step();
        host_req_we = 1'b0;
    endtask

    task automatic wr_prio(input int ch, input int code);
        host_prio_we = 1'b1; host_prio_ch = 4'(ch); host_prio_code = 2'(code);
        step();
        host_prio_we = 1'b0;
    endtask

    task automatic serve(input int exp, input string tag, input bit hold);
        int n;
        n = 0;
        while (!svc_valid && n < 12) begin step(); n++; end
        chk(svc_valid && svc_ch == 4'(exp), tag, svc_valid ? int'(svc_ch) : -1, exp);
        if (!hold) begin
            svc_done = 1'b1;
            step();
            svc_done = 1'b0;
        end
    endtask

    task automatic release_grant();
        svc_done = 1'b1;
        step();
        svc_done = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic report();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL R6 watchdog expired actual=hung expected=finished");
        report();
    end

    initial begin
        int rq, pr;
        do_reset();

        // R1 reset state
        chk(!svc_valid, "R1 svc_valid after reset", svc_valid, 0);
        chk(!host_wr_err, "R1 host_wr_err after reset", host_wr_err, 0);
        for (int c = 0; c < N; c++) begin
            probe(c, rq, pr);
            chk(rq == 0 && pr == 0, "R1 fields after reset", rq * 4 + pr, 0);
            step();
        end

        // R2 store, R5 disabled channel stays unserved
        wr_req(3, 2);
        probe(3, rq, pr);
        chk(rq == 2, "R2 stored code", rq, 2);
        for (int k = 0; k < 4; k++) begin
            step();
            chk(!svc_valid, "R5 disabled pending not granted", svc_valid, 0);
        end
        wr_req(5, 0);
        probe(5, rq, pr);
        chk(rq == 0, "R2 zero write keeps idle", rq, 0);
        step();

        // R3 rejected write
        wr_req(3, 1);
        probe(3, rq, pr);
        chk(host_wr_err, "R3 error pulse", host_wr_err, 1);
        chk(rq == 2, "R3 field unchanged", rq, 2);
        step();
        chk(!host_wr_err, "R3 pulse is single", host_wr_err, 0);

        // R4 priority write, R6 grant and hold
        wr_prio(3, 3);
        probe(3, rq, pr);
        chk(pr == 3, "R4 priority stored", pr, 3);
        chk(!svc_valid, "R6 grant not yet", svc_valid, 0);
        step();
        chk(svc_valid && svc_ch == 3 && svc_code == 2, "R6 grant channel and code",
            {svc_valid, svc_ch, svc_code}, {1'b1, 4'd3, 2'd2});
        for (int k = 0; k < 3; k++) begin
            step();
            chk(svc_valid && svc_ch == 3 && svc_code == 2, "R6 grant held",
                {svc_valid, svc_ch, svc_code}, {1'b1, 4'd3, 2'd2});
        end
        release_grant();
        chk(!svc_valid, "R7 valid drops on done", svc_valid, 0);
        probe(3, rq, pr);
        chk(rq == 0, "R7 field cleared on done", rq, 0);
        step();

        // R9 downward fallback at a middle slot (slot 1)
        host_prio_we = 1'b1; host_prio_ch = 4'd7; host_prio_code = 2'd1;
        wr_req(7, 3);
        host_prio_we = 1'b0;
        serve(7, "R9 middle slot falls back to low", 1'b0);
        // R8 slot 2 is high
        wr_prio(9, 3);
        wr_req(9, 1);
        serve(9, "R8 high slot grant", 1'b0);
        // R9 upward fallback at the low slot (slot 3)
        wr_prio(10, 2);
        wr_req(10, 1);
        serve(10, "R9 low slot falls back upward", 1'b0);
        // R5 disabled pending again
        wr_req(11, 2);
        for (int k = 0; k < 5; k++) begin
            step();
            chk(!svc_valid, "R5 disabled channel 11 ignored", svc_valid, 0);
        end
        // R7 done without grant has no effect
        svc_done = 1'b1; step(); svc_done = 1'b0;
        probe(11, rq, pr);
        chk(rq == 2, "R7 stray done ignored", rq, 2);
        step();

        // R8 and R10 round order from a fresh reset
        do_reset();
        wr_prio(15, 3);
        wr_req(15, 1);
        serve(15, "R10 first high grant", 1'b1);
        wr_prio(2, 3); wr_prio(5, 3); wr_prio(12, 3);
        wr_prio(6, 2); wr_prio(9, 1);
        wr_req(2, 1); wr_req(5, 2); wr_req(12, 3); wr_req(6, 1); wr_req(9, 2);
        release_grant();
        serve(6, "R8 slot 1 middle", 1'b0);
        serve(2, "R10 ring wraps after 15", 1'b0);
        serve(9, "R8 slot 3 low", 1'b0);
        serve(5, "R10 next high after 2", 1'b0);
        serve(12, "R9 slot 5 falls upward", 1'b1);
        wr_req(5, 1); wr_req(2, 1);
        release_grant();
        serve(2, "R10 ring wraps after 12", 1'b0);
        serve(5, "R8 round restarts high", 1'b0);

        // random phase
        auto_en = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            host_req_we   = ($urandom_range(2) == 0);
            host_req_ch   = (svc_valid && $urandom_range(3) == 0) ? svc_ch : 4'($urandom_range(N - 1));
            host_req_code = 2'($urandom_range(3));
            host_prio_we  = ($urandom_range(9) == 0);
            host_prio_ch  = 4'($urandom_range(N - 1));
            host_prio_code = 2'($urandom_range(3));
            host_rd_ch    = 4'($urandom_range(N - 1));
            step();
        end
        host_req_we = 1'b0; host_prio_we = 1'b0;
        auto_en = 1'b0;
        step();
        svc_done = 1'b0;
        repeat (4) step();
        report();
    end

endmodule